// File: doc/BRIEF.md
# Multi-Format Pixel Expander with Colormap

This block turns one stored pixel word into a 32-bit ARGB value. A 3-bit format code on the same cycle says how the word is packed. Indexed 8-bit pixels are looked up in an on-block colormap RAM. The lookup address is the pixel index plus a per-window offset. True-colour formats are unpacked field by field. Each narrow field is widened to 8 bits by copying its top bits into the vacated low bits.

The colormap is loaded through a separate write port, which is independent of the pixel stream. A bypass input lets an 8-bit pixel skip the colormap and be read as a direct 3-3-2 colour instead. Every accepted pixel produces exactly one output, two clock cycles later, whatever its format. Between results, the output register keeps its last value.

Top module: `pxe_expander`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `out_valid` is 0 and `out_argb` is 0.
- R2: `out_valid` is 1 exactly two rising edges after each cycle with `in_valid` high, for back-to-back and isolated pixels alike. `out_argb` keeps its value in every cycle where no new result is produced.
- R3: Format code 0 with `in_bypass` low is an indexed lookup. The index is `in_pixel[7:0]` and bits 31:8 are ignored. The output is the colormap entry, returned unchanged. An entry holds alpha in bits 31:24, red in 23:16, green in 15:8 and blue in 7:0.
- R4: The lookup address is `in_pixel[7:0] + win_ofs*64`, taken modulo 1024.
- R5: A write with `cm_we` high and `cm_addr` below 1024 stores `cm_wdata` at that entry. A write with `cm_addr` from 1024 to 2047 changes no entry.
- R6: If a lookup and a write hit the same entry in the same cycle, the lookup returns the entry's old contents.
- R7: Format code 1 (565) has blue in bits 4:0, green in 10:5 and red in 15:11. Bits 31:16 are ignored. Each field is widened by replicating its top bits, and alpha is 0xFF.
- R8: Format code 2 (1555) has blue in bits 4:0, green in 9:5, red in 14:10 and alpha in bit 15. An alpha bit of 1 gives 0xFF and 0 gives 0x00.
- R9: Format code 4 passes bits 23:0 through as red, green and blue. Alpha is forced to 0xFF whatever bits 31:24 hold.
- R10: Format code 5 passes all 32 bits through as ARGB.
- R11: Format code 0 with `in_bypass` high reads the colormap for nothing. Red comes from bits 7:5, green from 4:2 and blue from 1:0, each widened by replication, and alpha is 0xFF. For all other codes `in_bypass` has no effect.
- R12: Format codes 3, 6 and 7 give a valid output of all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel present this cycle |
| in_pixel | input | 32 | Stored pixel word |
| in_fmt | input | 3 | Pixel format code |
| in_bypass | input | 1 | Skip colormap for 8-bit pixels |
| win_ofs | input | 4 | Window colormap offset, in units of 64 entries |
| cm_we | input | 1 | Colormap write enable |
| cm_addr | input | 11 | Colormap write index |
| cm_wdata | input | 32 | Colormap write data (ARGB) |
| out_valid | output | 1 | Result present this cycle |
| out_argb | output | 32 | Expanded ARGB result |

## Verification
A bad index sum or a broken offset wrap shows up as a wrong entry on the very next indexed result, two cycles after the pixel. It appears only for indices whose offset crosses the top of the table, so entries at 191 and 0 are reached through the wrap on purpose. A stage-1 register holding the wrong format lets the correct colormap data reach the wrong output path. That shows within one result as an alpha other than 0xFF on an opaque format, or as colormap contents where direct colour belongs. An out-of-range write that aliases into the table, or a read-during-write that returns new data, is only visible on the next lookup of that entry. The bench therefore reads such entries back immediately.

// File: rtl/pxe_pkg.sv
package pxe_pkg;

   localparam logic [2:0] PXF_IDX8     = 3'd0;
   localparam logic [2:0] PXF_RGB565   = 3'd1;
   localparam logic [2:0] PXF_ARGB1555 = 3'd2;
   localparam logic [2:0] PXF_RGB888   = 3'd4;
   localparam logic [2:0] PXF_ARGB8888 = 3'd5;

   localparam logic [7:0] ALPHA_OPAQUE = 8'hFF;

   function automatic logic [7:0] widen2(input logic [1:0] f);
      return {f, f, f, f};
   endfunction

   function automatic logic [7:0] widen3(input logic [2:0] f);
      return {f, f, f[2:1]};
   endfunction

   function automatic logic [7:0] widen5(input logic [4:0] f);
      return {f, f[4:2]};
   endfunction

   function automatic logic [7:0] widen6(input logic [5:0] f);
      return {f, f[5:4]};
   endfunction

   function automatic logic fmt_is_reserved(input logic [2:0] f);
      return (f == 3'd3) || (f == 3'd6) || (f == 3'd7);
   endfunction

endpackage

// File: rtl/pxe_cmap_ram.sv
module pxe_cmap_ram #(
   parameter int DEPTH   = 1024,
   parameter int DATA_W  = 32,
   parameter int WADDR_W = 11,
   localparam int IDX_W  = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               wr_en,
   input  logic [WADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               rd_en,
   input  logic [IDX_W-1:0]   rd_addr,
   output logic [DATA_W-1:0]  rd_data
);

   initial begin
      assert ((DEPTH & (DEPTH - 1)) == 0)
         else $error("pxe_cmap_ram: DEPTH must be a power of two");
      assert (WADDR_W >= IDX_W)
         else $error("pxe_cmap_ram: WADDR_W narrower than index");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic              in_range;

   generate
      if (WADDR_W > IDX_W) begin : g_wide_addr
         assign in_range = ~|wr_addr[WADDR_W-1:IDX_W];
      end else begin : g_exact_addr
         assign in_range = 1'b1;
      end
   endgenerate

   // Nonblocking read and write together give old data on a same-entry collision.
   always_ff @(posedge clk) begin
      if (wr_en && in_range)
         mem[wr_addr[IDX_W-1:0]] <= wr_data;
      if (rd_en)
         rd_data <= mem[rd_addr];
   end

endmodule

// File: rtl/pxe_unpack.sv
module pxe_unpack
   import pxe_pkg::*;
(
   input  logic [2:0]  fmt,
   input  logic [31:0] pix,
   output logic [31:0] argb,
   output logic        reserved
);

   assign reserved = fmt_is_reserved(fmt);

   always_comb begin
      argb = '0;
      case (fmt)
         PXF_IDX8:     argb = {ALPHA_OPAQUE, widen3(pix[7:5]), widen3(pix[4:2]),
                               widen2(pix[1:0])};
         PXF_RGB565:   argb = {ALPHA_OPAQUE, widen5(pix[15:11]), widen6(pix[10:5]),
                               widen5(pix[4:0])};
         PXF_ARGB1555: argb = {{8{pix[15]}}, widen5(pix[14:10]), widen5(pix[9:5]),
                               widen5(pix[4:0])};
         PXF_RGB888:   argb = {ALPHA_OPAQUE, pix[23:0]};
         PXF_ARGB8888: argb = pix;
         default:      argb = '0;
      endcase
   end

endmodule

// File: rtl/pxe_expander.sv
module pxe_expander
   import pxe_pkg::*;
#(
   parameter int CMAP_DEPTH = 1024,
   parameter int CM_ADDR_W  = 11,
   parameter int OFS_W      = 4,
   parameter int OFS_SHIFT  = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [31:0]          in_pixel,
   input  logic [2:0]           in_fmt,
   input  logic                 in_bypass,
   input  logic [OFS_W-1:0]     win_ofs,
   input  logic                 cm_we,
   input  logic [CM_ADDR_W-1:0] cm_addr,
   input  logic [31:0]          cm_wdata,
   output logic                 out_valid,
   output logic [31:0]          out_argb
);

   localparam int IDX_W = $clog2(CMAP_DEPTH);

   initial begin
      assert (IDX_W >= 8)
         else $error("pxe_expander: colormap smaller than 8-bit index range");
      assert (OFS_W + OFS_SHIFT <= IDX_W)
         else $error("pxe_expander: window offset exceeds index width");
   end

   // Stage 0: lookup address and RAM read launch
   logic             want_lookup;
   logic [IDX_W-1:0] lut_idx;

   assign want_lookup = (in_fmt == PXF_IDX8) && !in_bypass;
   assign lut_idx     = IDX_W'(in_pixel[7:0]) + (IDX_W'(win_ofs) << OFS_SHIFT);

   logic [31:0] rd_data;

   pxe_cmap_ram #(
      .DEPTH   (CMAP_DEPTH),
      .DATA_W  (32),
      .WADDR_W (CM_ADDR_W)
   ) u_cmap (
      .clk     (clk),
      .wr_en   (cm_we),
      .wr_addr (cm_addr),
      .wr_data (cm_wdata),
      .rd_en   (in_valid && want_lookup),
      .rd_addr (lut_idx),
      .rd_data (rd_data)
   );

   // Stage 1: hold the pixel alongside the RAM read
   logic        s1_valid;
   logic        s1_lookup;
   logic        s1_byp;
   logic [2:0]  s1_fmt;
   logic [31:0] s1_pix;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid  <= 1'b0;
         s1_lookup <= 1'b0;
         s1_byp    <= 1'b0;
         s1_fmt    <= '0;
         s1_pix    <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_lookup <= want_lookup;
            s1_byp    <= in_bypass;
            s1_fmt    <= in_fmt;
            s1_pix    <= in_pixel;
         end
      end
   end

   logic [31:0] direct_argb;
   logic        s1_reserved;

   pxe_unpack u_unpack (
      .fmt      (s1_fmt),
      .pix      (s1_pix),
      .argb     (direct_argb),
      .reserved (s1_reserved)
   );

   // Stage 2: output register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_argb  <= '0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid)
            out_argb <= s1_lookup ? rd_data : direct_argb;
      end
   end

   // Assertions
   assert_in_to_s1_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> s1_valid);

   assert_s1_to_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |=> out_valid);

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_valid |=> (!out_valid && $stable(out_argb)));

   assert_lookup_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_lookup) |=> (out_argb == $past(rd_data)));

   assert_alpha_binary_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_fmt == PXF_ARGB1555)
         |=> (out_argb[31:24] == 8'h00 || out_argb[31:24] == 8'hFF));

   assert_alpha_opaque_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && (s1_fmt == PXF_RGB565 || s1_fmt == PXF_RGB888
                    || (s1_fmt == PXF_IDX8 && s1_byp)))
         |=> (out_argb[31:24] == ALPHA_OPAQUE));

   assert_reserved_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_reserved) |=> (out_argb == 32'h0));

endmodule

// File: tb/tb_pxe_expander.sv
module tb_pxe_expander;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [31:0] in_pixel;
   logic [2:0]  in_fmt;
   logic        in_bypass;
   logic [3:0]  win_ofs;
   logic        cm_we;
   logic [10:0] cm_addr;
   logic [31:0] cm_wdata;
   logic        out_valid;
   logic [31:0] out_argb;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   pxe_expander dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_pixel  (in_pixel),
      .in_fmt    (in_fmt),
      .in_bypass (in_bypass),
      .win_ofs   (win_ofs),
      .cm_we     (cm_we),
      .cm_addr   (cm_addr),
      .cm_wdata  (cm_wdata),
      .out_valid (out_valid),
      .out_argb  (out_argb)
   );

   typedef struct packed {
      logic [2:0]  fmt;
      logic        byp;
      logic [31:0] pix;
      logic [31:0] exp;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VECS [NV] = '{
      '{3'd1, 1'b0, 32'h0000FFFF, 32'hFFFFFFFF},  // R7 all ones
      '{3'd1, 1'b0, 32'hABCDF800, 32'hFFFF0000},  // R7 red only, upper bits ignored
      '{3'd1, 1'b0, 32'h000007E0, 32'hFF00FF00},  // R7 green 6-bit
      '{3'd1, 1'b0, 32'h00008410, 32'hFF848284},  // R7 replication
      '{3'd2, 1'b0, 32'h0000FFFF, 32'hFFFFFFFF},  // R8 opaque white
      '{3'd2, 1'b0, 32'h00007C00, 32'h00FF0000},  // R8 alpha bit clear
      '{3'd2, 1'b0, 32'h00008001, 32'hFF000008},  // R8 low blue
      '{3'd2, 1'b0, 32'h000003E0, 32'h0000FF00},  // R8 green
      '{3'd4, 1'b0, 32'h12345678, 32'hFF345678},  // R9 alpha forced
      '{3'd5, 1'b0, 32'h12345678, 32'h12345678},  // R10 pass
      '{3'd0, 1'b1, 32'h000000E0, 32'hFFFF0000},  // R11 red
      '{3'd0, 1'b1, 32'h0000001C, 32'hFF00FF00},  // R11 green
      '{3'd0, 1'b1, 32'h00000003, 32'hFF0000FF},  // R11 blue
      '{3'd0, 1'b1, 32'h000000A5, 32'hFFB62455},  // R11 mixed
      '{3'd0, 1'b1, 32'h00000005, 32'hFF002455},  // R11 colormap not used
      '{3'd3, 1'b0, 32'hFFFFFFFF, 32'h00000000},  // R12
      '{3'd6, 1'b0, 32'hFFFFFFFF, 32'h00000000},  // R12
      '{3'd7, 1'b0, 32'h12345678, 32'h00000000},  // R12
      '{3'd4, 1'b1, 32'hAABBCCDD, 32'hFFBBCCDD},  // R11 ignored on R9 format
      '{3'd5, 1'b1, 32'h01020304, 32'h01020304},  // R11 ignored on R10 format
      '{3'd2, 1'b1, 32'h00000000, 32'h00000000}   // R11 ignored on R8 format
   };

   function automatic string req_of(input logic [2:0] f, input logic b);
      case (f)
         3'd0:    return b ? "R11" : "R3";
         3'd1:    return "R7";
         3'd2:    return "R8";
         3'd4:    return "R9";
         3'd5:    return "R10";
         default: return "R12";
      endcase
   endfunction

   task automatic chk(input logic ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cm_write(input logic [10:0] a, input logic [31:0] d);
      @(negedge clk);
      cm_we = 1'b1; cm_addr = a; cm_wdata = d;
      @(negedge clk);
      cm_we = 1'b0;
   endtask

   // Drive one pixel, then sample two rising edges later.
   task automatic run_pix(input logic [2:0] f, input logic b, input logic [31:0] p,
                          input logic [3:0] o, input logic [31:0] exp, input string req);
      @(negedge clk);
      in_valid = 1'b1; in_fmt = f; in_bypass = b; in_pixel = p; win_ofs = o;
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      chk(out_valid === 1'b1, {req, " valid"}, {31'd0, out_valid}, 32'd1);
      chk(out_argb === exp, req, out_argb, exp);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_pixel = '0; in_fmt = '0; in_bypass = 1'b0;
      win_ofs = '0; cm_we = 1'b0; cm_addr = '0; cm_wdata = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(out_valid === 1'b0, "R1", {31'd0, out_valid}, 32'd0);
      chk(out_argb === 32'h0, "R1", out_argb, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid === 1'b0, "R1", {31'd0, out_valid}, 32'd0);

      // Direct formats and bypass from the vector table
      for (int i = 0; i < NV; i++)
         run_pix(VECS[i].fmt, VECS[i].byp, VECS[i].pix, 4'd0, VECS[i].exp,
                 req_of(VECS[i].fmt, VECS[i].byp));

      // Colormap load (R5)
      cm_write(11'd5,    32'h11223344);
      cm_write(11'd69,   32'h55667788);
      cm_write(11'd1023, 32'hCAFEF00D);
      cm_write(11'd191,  32'h0BADBEEF);
      cm_write(11'd0,    32'hA0A0A0A0);

      // R3 indexed lookups, upper pixel bits ignored
      run_pix(3'd0, 1'b0, 32'h00000005, 4'd0,  32'h11223344, "R3");
      run_pix(3'd0, 1'b0, 32'hFFFFFF05, 4'd0,  32'h11223344, "R3");
      // R4 window offset
      run_pix(3'd0, 1'b0, 32'h00000005, 4'd1,  32'h55667788, "R4");
      run_pix(3'd0, 1'b0, 32'h000000FF, 4'd12, 32'hCAFEF00D, "R4");
      run_pix(3'd0, 1'b0, 32'h000000FF, 4'd15, 32'h0BADBEEF, "R4 wrap");
      run_pix(3'd0, 1'b0, 32'h000000C0, 4'd13, 32'hA0A0A0A0, "R4 wrap");

      // R5 out-of-range writes change nothing
      cm_write(11'd1029, 32'hDEADDEAD);
      cm_write(11'd2047, 32'hDEADDEAD);
      run_pix(3'd0, 1'b0, 32'h00000005, 4'd0,  32'h11223344, "R5");
      run_pix(3'd0, 1'b0, 32'h000000FF, 4'd12, 32'hCAFEF00D, "R5");

      // R6 read during write to the same entry
      @(negedge clk);
      cm_we = 1'b1; cm_addr = 11'd5; cm_wdata = 32'h99999999;
      in_valid = 1'b1; in_fmt = 3'd0; in_bypass = 1'b0; in_pixel = 32'h5; win_ofs = 4'd0;
      @(negedge clk);
      cm_we = 1'b0; in_valid = 1'b0;
      @(negedge clk);
      chk(out_argb === 32'h11223344, "R6 old data", out_argb, 32'h11223344);
      run_pix(3'd0, 1'b0, 32'h00000005, 4'd0, 32'h99999999, "R6 new data");

      // R2 back-to-back stream
      @(negedge clk);
      in_valid = 1'b1; in_fmt = 3'd5; in_bypass = 1'b0; in_pixel = 32'hA1A1A1A1;
      @(negedge clk);
      chk(out_valid === 1'b0, "R2 no early valid", {31'd0, out_valid}, 32'd0);
      in_pixel = 32'hB2B2B2B2;
      @(negedge clk);
      chk(out_valid === 1'b1 && out_argb === 32'hA1A1A1A1, "R2", out_argb, 32'hA1A1A1A1);
      in_pixel = 32'hC3C3C3C3;
      @(negedge clk);
      chk(out_valid === 1'b1 && out_argb === 32'hB2B2B2B2, "R2", out_argb, 32'hB2B2B2B2);
      in_valid = 1'b0;
      @(negedge clk);
      chk(out_valid === 1'b1 && out_argb === 32'hC3C3C3C3, "R2", out_argb, 32'hC3C3C3C3);
      @(negedge clk);
      chk(out_valid === 1'b0, "R2 drop", {31'd0, out_valid}, 32'd0);
      chk(out_argb === 32'hC3C3C3C3, "R2 hold", out_argb, 32'hC3C3C3C3);

      // R1 reset in mid-stream clears the output
      @(negedge clk);
      in_valid = 1'b1; in_pixel = 32'h77777777;
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0;
      @(negedge clk);
      chk(out_valid === 1'b0 && out_argb === 32'h0, "R1 mid reset", out_argb, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(out_valid === 1'b0, "R1 after reset", {31'd0, out_valid}, 32'd0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule